// File: doc/BRIEF.md
# Compare-Match Timer with Output Control

This block is an up-counting timer with two comparators. Comparator A compares the whole counter against a full-width compare value. Comparator P compares a short period value against the top bits of the counter. With the low bits at zero, a period match falls on a multiple of 2^(CNT_W-PER_W) counts. Each comparator has its own sticky interrupt flag. A clear-select input chooses which comparator's match returns the counter to zero. The other comparator then only signals, or in the case of Comparator P, stays silent.

A single output pin follows Comparator A events only. On each such event the pin can hold its level, go low, go high or toggle. Each rising edge of the enable input reloads the pin with a programmable initial level. A polarity input inverts the level that appears at the output. The enable and pause inputs control the counter. Pause freezes the count. Dropping enable stops the counter and zeroes it, so the next enable starts again from zero.

Top module: `cmt_timer`

## Requirements
- R1: After a synchronous reset, the count is 0, both flags are 0, and `pin_out` equals `pol` (the internal level resets to 0).
- R2: While `en` is 1 and `pause` is 0, the count goes up by one on each clock. When no clear applies, it wraps from 2^CNT_W-1 to 0. The first clock with `en` high takes the count from 0 to 1.
- R3: With `clr_sel` = 1 and `cmp_a` nonzero, a running count equal to `cmp_a` sets `flag_a` and returns the count to 0 on the next clock.
- R4: With `clr_sel` = 0 and `period` nonzero, a running count whose top PER_W bits equal `period` and whose lower bits are all zero sets `flag_p` and returns the count to 0 on the next clock.
- R5: While `clr_sel` = 1, `flag_p` is never set. This holds even when the period point comes before the `cmp_a` value.
- R6: When `cmp_a` is 0, `flag_a` is never set and Comparator A clears nothing, so the counter wraps at its all-ones value.
- R7: When `period` is 0, Comparator P neither clears the counter nor sets `flag_p`, so the counter wraps at its all-ones value.
- R8: On a Comparator A event, `pin_act` selects the pin action: 2'b00 holds the level, 2'b01 drives it low, 2'b10 drives it high, and 2'b11 inverts it.
- R9: Comparator P matches never change the pin level.
- R10: On the first clock with `en` high after a clock with `en` low, the pin level loads `init_lvl`. Every new enable edge does this again.
- R11: `pin_out` is the pin level XOR `pol`, and it responds to `pol` without a clock.
- R12: While `en` is 1 and `pause` is 1, the count holds its value. Dropping `pause` resumes counting from that value. While `en` is 0, the count is 0 on the next clock.
- R13: Each flag stays set until its clear input is high at a clock. If a match and the clear fall on the same clock, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; its rising edge restarts the count and the pin |
| pause | input | 1 | Holds the count while high |
| clr_sel | input | 1 | 0: Comparator P clears the count; 1: Comparator A clears it |
| cmp_a | input | CNT_W | Comparator A compare value |
| period | input | PER_W | Comparator P period value (top counter bits) |
| pin_act | input | 2 | Pin action on a Comparator A event |
| init_lvl | input | 1 | Pin level loaded on enable rising edge |
| pol | input | 1 | Inverts the output pin when high |
| clr_a_flag | input | 1 | Clears flag_a |
| clr_p_flag | input | 1 | Clears flag_p |
| count | output | CNT_W | Current counter value |
| flag_a | output | 1 | Sticky Comparator A flag |
| flag_p | output | 1 | Sticky Comparator P flag |
| pin_out | output | 1 | Output pin after polarity |

## Verification
The bench builds the timer with CNT_W = 10 and PER_W = 3. A full wrap then takes 1024 clocks, and one period step is 128 counts. With these values, the wrap cases for a zero compare value and a zero period can be observed directly. So can period matches, and the case where the period point comes before the Comparator A value. Every check uses the exact clock counts these sizes give, which also covers the reload on enable and the toggle sequence.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } pin_act_e;

    typedef struct packed {
        logic hit_a;   // Comparator A event (flag and pin)
        logic hit_p;   // Comparator P event (flag)
        logic clr;     // selected clear source
    } match_s;

    localparam int NUM_FLAGS = 2;
    localparam int FLAG_A    = 0;
    localparam int FLAG_P    = 1;

    function automatic logic next_level(input pin_act_e act, input logic cur);
        logic nxt;
        case (act)
            ACT_LOW:    nxt = 1'b0;
            ACT_HIGH:   nxt = 1'b1;
            ACT_TOGGLE: nxt = ~cur;
            default:    nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/cmt_counter.sv
module cmt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             pause,
    input  logic             clr_now,
    output logic [CNT_W-1:0] count,
    output logic             run,
    output logic             start
);
    logic en_q;

    assign run   = en & ~pause;
    assign start = en & ~en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (!en) begin
            count <= '0;
        end else if (run) begin
            if (clr_now) begin
                count <= '0;
            end else begin
                count <= count + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/cmt_compare.sv
module cmt_compare
    import cmt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PER_W = 3
) (
    input  logic [CNT_W-1:0] count,
    input  logic             run,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [PER_W-1:0] period,
    input  logic             clr_sel,
    output match_s           ev
);
    localparam int LOW_W = CNT_W - PER_W;

    logic a_raw;
    logic p_raw;

    always_comb begin
        a_raw = run && (cmp_a != '0) && (count == cmp_a);
        p_raw = run && (period != '0) && (count[CNT_W-1:LOW_W] == period)
                && (count[LOW_W-1:0] == '0);
        ev.hit_a = a_raw;
        ev.hit_p = p_raw && !clr_sel;
        ev.clr   = clr_sel ? a_raw : p_raw;
    end

endmodule

// File: rtl/cmt_flag.sv
module cmt_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/cmt_pin.sv
module cmt_pin
    import cmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       hit_a,
    input  logic [1:0] pin_act,
    input  logic       init_lvl,
    input  logic       pol,
    output logic       level,
    output logic       pin_out
);
    pin_act_e act;

    assign act     = pin_act_e'(pin_act);
    assign pin_out = level ^ pol;

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= 1'b0;
        end else if (start) begin
            level <= init_lvl;
        end else if (hit_a) begin
            level <= next_level(act, level);
        end
    end
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
    import cmt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PER_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             pause,
    input  logic             clr_sel,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [PER_W-1:0] period,
    input  logic [1:0]       pin_act,
    input  logic             init_lvl,
    input  logic             pol,
    input  logic             clr_a_flag,
    input  logic             clr_p_flag,
    output logic [CNT_W-1:0] count,
    output logic             flag_a,
    output logic             flag_p,
    output logic             pin_out
);
    match_s                 ev;
    logic                   run;
    logic                   start;
    logic                   clr_now;
    logic                   level;
    logic [NUM_FLAGS-1:0]   fset;
    logic [NUM_FLAGS-1:0]   fclr;
    logic [NUM_FLAGS-1:0]   fval;

    assign clr_now = ev.clr;

    cmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .pause   (pause),
        .clr_now (clr_now),
        .count   (count),
        .run     (run),
        .start   (start)
    );

    cmt_compare #(.CNT_W(CNT_W), .PER_W(PER_W)) u_cmp (
        .count   (count),
        .run     (run),
        .cmp_a   (cmp_a),
        .period  (period),
        .clr_sel (clr_sel),
        .ev      (ev)
    );

    assign fset[FLAG_A] = ev.hit_a;
    assign fset[FLAG_P] = ev.hit_p;
    assign fclr[FLAG_A] = clr_a_flag;
    assign fclr[FLAG_P] = clr_p_flag;

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        cmt_flag u_flag (
            .clk  (clk),
            .rst  (rst),
            .set  (fset[i]),
            .clr  (fclr[i]),
            .flag (fval[i])
        );
    end

    assign flag_a = fval[FLAG_A];
    assign flag_p = fval[FLAG_P];

    cmt_pin u_pin (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .hit_a    (ev.hit_a),
        .pin_act  (pin_act),
        .init_lvl (init_lvl),
        .pol      (pol),
        .level    (level),
        .pin_out  (pin_out)
    );

endmodule

// File: rtl/cmt_timer_checker.sv
module cmt_timer_checker #(
    parameter int CNT_W = 16,
    parameter int PER_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             pause,
    input logic             clr_sel,
    input logic [CNT_W-1:0] cmp_a,
    input logic             init_lvl,
    input logic             pol,
    input logic             clr_a_flag,
    input logic             clr_now,
    input logic [CNT_W-1:0] count,
    input logic             flag_a,
    input logic             flag_p,
    input logic             pin_out
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (count == '0) && !flag_a && !flag_p);

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (en && !pause && !clr_now) |=> count == $past(count) + CNT_W'(1));

    p_pause_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (en && pause) |=> count == $past(count));

    p_stop_zero_r12: assert property (@(posedge clk) disable iff (rst)
        !en |=> count == '0);

    p_no_pflag_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_sel && !flag_p) |=> !flag_p);

    p_zero_cmp_r6: assert property (@(posedge clk) disable iff (rst)
        (cmp_a == '0 && !flag_a) |=> !flag_a);

    p_flag_sticky_r13: assert property (@(posedge clk) disable iff (rst)
        (flag_a && !clr_a_flag) |=> flag_a);

    p_enable_load_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |=> pin_out == ($past(init_lvl) ^ pol));
endmodule

bind cmt_timer cmt_timer_checker #(.CNT_W(CNT_W), .PER_W(PER_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .pause      (pause),
    .clr_sel    (clr_sel),
    .cmp_a      (cmp_a),
    .init_lvl   (init_lvl),
    .pol        (pol),
    .clr_a_flag (clr_a_flag),
    .clr_now    (clr_now),
    .count      (count),
    .flag_a     (flag_a),
    .flag_p     (flag_p),
    .pin_out    (pin_out)
);

// File: tb/cmt_timer_bench.sv
module cmt_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 10;
    localparam int PER_W      = 3;

    logic             clk = 1'b0;
    logic             rst;
    logic             en;
    logic             pause;
    logic             clr_sel;
    logic [CNT_W-1:0] cmp_a;
    logic [PER_W-1:0] period;
    logic [1:0]       pin_act;
    logic             init_lvl;
    logic             pol;
    logic             clr_a_flag;
    logic             clr_p_flag;
    logic [CNT_W-1:0] count;
    logic             flag_a;
    logic             flag_p;
    logic             pin_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmt_timer #(.CNT_W(CNT_W), .PER_W(PER_W)) u_cmt_timer (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .pause      (pause),
        .clr_sel    (clr_sel),
        .cmp_a      (cmp_a),
        .period     (period),
        .pin_act    (pin_act),
        .init_lvl   (init_lvl),
        .pol        (pol),
        .clr_a_flag (clr_a_flag),
        .clr_p_flag (clr_p_flag),
        .count      (count),
        .flag_a     (flag_a),
        .flag_p     (flag_p),
        .pin_out    (pin_out)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic setup(input int c, input int p, input bit sel,
                         input int act, input bit init, input bit pl);
        en = 1'b0;
        pause = 1'b0;
        cmp_a = CNT_W'(c);
        period = PER_W'(p);
        clr_sel = sel;
        pin_act = 2'(act);
        init_lvl = init;
        pol = pl;
        clr_a_flag = 1'b1;
        clr_p_flag = 1'b1;
        tick(1);
        clr_a_flag = 1'b0;
        clr_p_flag = 1'b0;
        en = 1'b1;
    endtask

    task automatic t_reset;
        rst = 1'b1; en = 1'b0; pause = 1'b0; clr_sel = 1'b0;
        cmp_a = '0; period = '0; pin_act = 2'b00; init_lvl = 1'b0;
        pol = 1'b1; clr_a_flag = 1'b0; clr_p_flag = 1'b0;
        tick(3);
        rst = 1'b0;
        chk("R1 count", int'(count), 0);
        chk("R1 flag_a", int'(flag_a), 0);
        chk("R1 flag_p", int'(flag_p), 0);
        chk("R1 pin_out", int'(pin_out), 1);
    endtask

    task automatic t_count_pause_stop;
        setup(0, 0, 1'b1, 0, 1'b0, 1'b0);
        tick(10);
        chk("R2 count after 10", int'(count), 10);
        pause = 1'b1;
        tick(5);
        chk("R12 paused", int'(count), 10);
        pause = 1'b0;
        tick(3);
        chk("R12 resumed", int'(count), 13);
        en = 1'b0;
        tick(1);
        chk("R12 stopped", int'(count), 0);
        en = 1'b1;
        tick(4);
        chk("R12 restart", int'(count), 4);
    endtask

    task automatic t_clear_a;
        setup(50, 1, 1'b1, 0, 1'b0, 1'b0);
        tick(50);
        chk("R3 count at match", int'(count), 50);
        chk("R3 flag before", int'(flag_a), 0);
        tick(1);
        chk("R3 count cleared", int'(count), 0);
        chk("R3 flag_a set", int'(flag_a), 1);
        tick(5);
        chk("R13 flag_a sticky", int'(flag_a), 1);
        clr_a_flag = 1'b1;
        tick(1);
        clr_a_flag = 1'b0;
        chk("R13 flag_a cleared", int'(flag_a), 0);
    endtask

    task automatic t_clear_p;
        setup(0, 2, 1'b0, 0, 1'b0, 1'b0);
        tick(256);
        chk("R4 count at period", int'(count), 256);
        chk("R4 flag before", int'(flag_p), 0);
        tick(1);
        chk("R4 count cleared", int'(count), 0);
        chk("R4 flag_p set", int'(flag_p), 1);
    endtask

    task automatic t_no_pflag;
        setup(300, 1, 1'b1, 0, 1'b0, 1'b0);
        tick(129);
        chk("R5 count passes period", int'(count), 129);
        chk("R5 flag_p quiet", int'(flag_p), 0);
    endtask

    task automatic t_wraps;
        setup(0, 7, 1'b1, 3, 1'b0, 1'b0);
        tick(1023);
        chk("R6 count at top", int'(count), 1023);
        tick(1);
        chk("R6 wrapped", int'(count), 0);
        chk("R6 flag_a quiet", int'(flag_a), 0);
        chk("R6 pin unchanged", int'(pin_out), 0);
        setup(0, 0, 1'b0, 0, 1'b0, 1'b0);
        tick(1024);
        chk("R7 wrapped", int'(count), 0);
        chk("R7 flag_p quiet", int'(flag_p), 0);
    endtask

    task automatic t_pin_actions;
        setup(20, 0, 1'b1, 1, 1'b1, 1'b0);
        tick(1);
        chk("R10 init loaded", int'(pin_out), 1);
        tick(20);
        chk("R8 act low", int'(pin_out), 0);
        setup(20, 0, 1'b1, 2, 1'b0, 1'b0);
        tick(21);
        chk("R8 act high", int'(pin_out), 1);
        setup(20, 0, 1'b1, 0, 1'b1, 1'b0);
        tick(21);
        chk("R8 act hold", int'(pin_out), 1);
        chk("R8 hold event flagged", int'(flag_a), 1);
        setup(20, 0, 1'b1, 3, 1'b0, 1'b0);
        tick(21);
        chk("R8 toggle first", int'(pin_out), 1);
        tick(21);
        chk("R8 toggle second", int'(pin_out), 0);
    endtask

    task automatic t_pin_p_ignored;
        setup(500, 1, 1'b0, 3, 1'b1, 1'b0);
        tick(129);
        chk("R9 p cleared", int'(count), 0);
        chk("R9 p flagged", int'(flag_p), 1);
        chk("R9 pin unchanged", int'(pin_out), 1);
    endtask

    task automatic t_pol_restart;
        setup(20, 0, 1'b1, 3, 1'b0, 1'b1);
        tick(1);
        chk("R11 inverted init", int'(pin_out), 1);
        tick(20);
        chk("R11 inverted toggle", int'(pin_out), 0);
        pol = 1'b0;
        #1;
        chk("R11 pol direct", int'(pin_out), 1);
        pol = 1'b1;
        en = 1'b0;
        tick(1);
        en = 1'b1;
        tick(1);
        chk("R10 reload on new enable", int'(pin_out), 1);
    endtask

    task automatic t_flag_priority;
        setup(20, 0, 1'b1, 0, 1'b0, 1'b0);
        tick(20);
        clr_a_flag = 1'b1;
        tick(1);
        clr_a_flag = 1'b0;
        chk("R13 set beats clear", int'(flag_a), 1);
    endtask

    initial begin
        t_reset;
        t_count_pause_stop;
        t_clear_a;
        t_clear_p;
        t_no_pflag;
        t_wraps;
        t_pin_actions;
        t_pin_p_ignored;
        t_pol_restart;
        t_flag_priority;
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule